// File: doc/BRIEF.md
# Colour-Channel Window Interrupt with Persistence Filter

This block watches the stream of conversion results from a three-colour light sensor and raises an interrupt when the chosen colour leaves a programmable 16-bit window often enough in a row. Each result arrives as a one-cycle pulse tagged with its colour. Only results from the colour picked by the channel selector are compared against the thresholds. A consecutive-miss counter filters out single spikes. When the programmed run length is reached, a sticky threshold flag is set. The flag stays set until the status register is read, which the register file signals with a one-cycle clear strobe.

A second sticky flag can record conversion completion when that source is enabled. Either flag pulls the shared interrupt pad low. The pad is modelled as open drain: the block only asserts an output enable that sinks the line and never drives it high. In sync mode the block releases the pad. It then watches the pad as an input and emits a one-cycle conversion-start pulse on each synchronised rising edge. The flags keep updating in sync mode, because conversions do not stop while an interrupt is pending.

Register decoding, byte access and the converter itself are outside this block. It receives the configuration fields and the result pulses as plain inputs.

Top module: `colour_window_irq`

## Requirements
- R1: After reset both flags are 0, the pad enable `int_oe` is 0, `sync_start` is 0, and the consecutive-miss count is zero.
- R2: Channel select `chan_sel` uses 2'b00 = none, 2'b01 = green, 2'b10 = red, 2'b11 = blue, with the same codes on `res_chan`. With 2'b00 the threshold flag is never set. A result whose `res_chan` differs from `chan_sel` neither advances nor resets the count.
- R3: A selected result is out of window when it is less than or equal to the low threshold, or strictly greater than the high threshold. A value equal to the high threshold, or one above the low threshold, is in window.
- R4: Each threshold is assembled as {msb byte, lsb byte}, with the `*_msb` input giving bits 15:8 and the `*_lsb` input giving bits 7:0.
- R5: `persist_sel` sets the run of consecutive out-of-window selected results needed to set the flag: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8. The flag rises in the cycle after the clock edge that takes in the last result of the run.
- R6: An in-window selected result resets the count to zero. While the count stays at the target, every further out-of-window selected result triggers again.
- R7: The threshold flag stays high until `stat_clr` is sampled high, and it falls on that edge.
- R8: If a trigger and `stat_clr` come in the same cycle, the trigger wins and the flag stays high.
- R9: When `done_irq_en` = 1, a `conv_done` pulse sets the sticky `done_flag`. `stat_clr` clears it, and a new `conv_done` in the same cycle wins. When `done_irq_en` = 0, `conv_done` is ignored.
- R10: `int_oe` is 1 exactly when `sync_mode` = 0 and at least one flag is set. In sync mode the flags still update, but the pad is never pulled.
- R11: In sync mode, a rising edge on `int_pin_in` produces exactly one single-cycle `sync_start` pulse after the synchroniser delay. With `sync_mode` = 0, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse: a new conversion result is present |
| res_chan | input | 2 | Colour code of the result (01 green, 10 red, 11 blue) |
| res_data | input | 16 | Conversion result |
| chan_sel | input | 2 | Colour that feeds the window compare (00 none) |
| persist_sel | input | 2 | Consecutive-miss run length code |
| thr_lo_lsb | input | 8 | Low threshold bits 7:0 |
| thr_lo_msb | input | 8 | Low threshold bits 15:8 |
| thr_hi_lsb | input | 8 | High threshold bits 7:0 |
| thr_hi_msb | input | 8 | High threshold bits 15:8 |
| done_irq_en | input | 1 | Let conversion completion set the done flag |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| stat_clr | input | 1 | One-cycle strobe: status register read completed |
| sync_mode | input | 1 | Release the pad and use it as a conversion-start input |
| int_pin_in | input | 1 | Level seen on the interrupt pad |
| int_oe | output | 1 | Pull-down enable for the open-drain pad |
| thr_flag | output | 1 | Sticky threshold interrupt flag |
| done_flag | output | 1 | Sticky conversion-done flag |
| sync_start | output | 1 | One-cycle conversion-start pulse in sync mode |

## Verification
The bench targets the window edges: results exactly at the low threshold and exactly at the high threshold, and one count past each. A design that uses strict compares at the wrong edge sets the flag one code early or late. It also sends runs of misses that are one short of each persistence setting, interleaves results from other colours, and breaks runs with a single in-window value. An off-by-one counter, or one that other colours reset, fires early, fires late or never fires. A clear strobe placed in the same cycle as a trigger catches a design that gives the clear priority and drops the interrupt. Sync-mode checks expose a block that still sinks the pad, or one that emits several start pulses, or pulses outside sync mode.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int SYNC_N  = 2;

  typedef enum logic [1:0] {
    CH_NONE  = 2'b00,
    CH_GREEN = 2'b01,
    CH_RED   = 2'b10,
    CH_BLUE  = 2'b11
  } chan_e;
endpackage

// File: rtl/cwi_window_cmp.sv
module cwi_window_cmp #(
  parameter int BYTE_W = cwi_pkg::BYTE_W
) (
  input  logic [BYTE_W-1:0]   lo_lsb,
  input  logic [BYTE_W-1:0]   lo_msb,
  input  logic [BYTE_W-1:0]   hi_lsb,
  input  logic [BYTE_W-1:0]   hi_msb,
  input  logic [2*BYTE_W-1:0] sample,
  output logic                outside
);
  localparam int W = 2 * BYTE_W;

  logic [W-1:0] lo_thr;
  logic [W-1:0] hi_thr;

  always_comb begin
    lo_thr  = {lo_msb, lo_lsb};
    hi_thr  = {hi_msb, hi_lsb};
    // inclusive at the low edge, exclusive at the high edge (R3)
    outside = (sample <= lo_thr) || (sample > hi_thr);
  end
endmodule

// File: rtl/cwi_persist.sv
module cwi_persist #(
  parameter int CNT_W = cwi_pkg::CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_none,
  input  logic       hit,
  input  logic       outside,
  input  logic [1:0] persist_sel,
  output logic       trig
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] bumped;
  logic             cnt_en;

  always_comb begin
    target = CNT_W'(1) << persist_sel;
    bumped = cnt_q + CNT_W'(1);
    if (bumped > target) bumped = target;
    cnt_d  = cnt_q;
    trig   = 1'b0;
    cnt_en = 1'b0;
    if (sel_none) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (hit) begin
      cnt_en = 1'b1;
      if (outside) begin
        cnt_d = bumped;
        trig  = (bumped == target);
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cwi_flags.sv
module cwi_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_req,
  input  logic             clr,
  output logic [NFLAG-1:0] flag
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic q, d, en;

    always_comb begin
      en = set_req[g] | clr;
      d  = set_req[g];   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign flag[g] = q;
  end
endmodule

// File: rtl/cwi_pin.sv
module cwi_pin #(
  parameter int SYNC_N = cwi_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic sync_mode,
  input  logic any_flag,
  output logic int_oe,
  output logic sync_start
);
  logic [SYNC_N-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d    = {chain_q[SYNC_N-2:0], pin_in};
    sync_start = sync_mode & chain_q[SYNC_N-1] & ~prev_q;
    int_oe     = ~sync_mode & any_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[SYNC_N-1];
    end
  end
endmodule

// File: rtl/colour_window_irq.sv
module colour_window_irq #(
  parameter int BYTE_W = cwi_pkg::BYTE_W,
  parameter int CNT_W  = cwi_pkg::CNT_W,
  parameter int SYNC_N = cwi_pkg::SYNC_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_valid,
  input  logic [1:0]          res_chan,
  input  logic [2*BYTE_W-1:0] res_data,
  input  logic [1:0]          chan_sel,
  input  logic [1:0]          persist_sel,
  input  logic [BYTE_W-1:0]   thr_lo_lsb,
  input  logic [BYTE_W-1:0]   thr_lo_msb,
  input  logic [BYTE_W-1:0]   thr_hi_lsb,
  input  logic [BYTE_W-1:0]   thr_hi_msb,
  input  logic                done_irq_en,
  input  logic                conv_done,
  input  logic                stat_clr,
  input  logic                sync_mode,
  input  logic                int_pin_in,
  output logic                int_oe,
  output logic                thr_flag,
  output logic                done_flag,
  output logic                sync_start
);
  import cwi_pkg::*;

  chan_e      sel;
  logic       sel_none;
  logic       hit;
  logic       outside;
  logic       trig;
  logic [1:0] set_req;
  logic [1:0] flags;

  always_comb begin
    sel      = chan_e'(chan_sel);
    sel_none = (sel == CH_NONE);
    hit      = res_valid && !sel_none && (res_chan == chan_sel);
    set_req  = {conv_done & done_irq_en, trig};
  end

  cwi_window_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .lo_lsb (thr_lo_lsb),
    .lo_msb (thr_lo_msb),
    .hi_lsb (thr_hi_lsb),
    .hi_msb (thr_hi_msb),
    .sample (res_data),
    .outside(outside)
  );

  cwi_persist #(.CNT_W(CNT_W)) u_persist (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_none   (sel_none),
    .hit        (hit),
    .outside    (outside),
    .persist_sel(persist_sel),
    .trig       (trig)
  );

  cwi_flags #(.NFLAG(2)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_req),
    .clr    (stat_clr),
    .flag   (flags)
  );

  assign thr_flag  = flags[0];
  assign done_flag = flags[1];

  cwi_pin #(.SYNC_N(SYNC_N)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (int_pin_in),
    .sync_mode (sync_mode),
    .any_flag  (flags[0] | flags[1]),
    .int_oe    (int_oe),
    .sync_start(sync_start)
  );
endmodule

// File: rtl/cwi_checker.sv
module cwi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [1:0] res_chan,
  input logic [1:0] chan_sel,
  input logic       done_irq_en,
  input logic       conv_done,
  input logic       stat_clr,
  input logic       sync_mode,
  input logic       int_oe,
  input logic       thr_flag,
  input logic       done_flag,
  input logic       sync_start
);
  assert_pad_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !int_oe);

  assert_pad_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_oe |-> (thr_flag || done_flag));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_flag && !stat_clr) |=> thr_flag);

  assert_flag_falls_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thr_flag) |-> $past(stat_clr));

  assert_rise_from_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_flag) |-> ($past(res_valid) && $past(chan_sel) != 2'b00
                         && $past(res_chan) == $past(chan_sel)));

  assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(conv_done && done_irq_en));

  assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> !sync_start);
endmodule

bind colour_window_irq cwi_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_chan   (res_chan),
  .chan_sel   (chan_sel),
  .done_irq_en(done_irq_en),
  .conv_done  (conv_done),
  .stat_clr   (stat_clr),
  .sync_mode  (sync_mode),
  .int_oe     (int_oe),
  .thr_flag   (thr_flag),
  .done_flag  (done_flag),
  .sync_start (sync_start)
);

// File: tb/sim_colour_window_irq.sv
`timescale 1ns/1ps
module sim_colour_window_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid, done_irq_en, conv_done, stat_clr, sync_mode, int_pin_in;
  logic [1:0]  res_chan, chan_sel, persist_sel;
  logic [15:0] res_data, lo_thr, hi_thr;
  logic        int_oe, thr_flag, done_flag, sync_start;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt;
  bit m_thr, m_done;

  always #5 clk = ~clk;

  colour_window_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .chan_sel(chan_sel), .persist_sel(persist_sel),
    .thr_lo_lsb(lo_thr[7:0]), .thr_lo_msb(lo_thr[15:8]),
    .thr_hi_lsb(hi_thr[7:0]), .thr_hi_msb(hi_thr[15:8]),
    .done_irq_en(done_irq_en), .conv_done(conv_done), .stat_clr(stat_clr),
    .sync_mode(sync_mode), .int_pin_in(int_pin_in),
    .int_oe(int_oe), .thr_flag(thr_flag), .done_flag(done_flag),
    .sync_start(sync_start)
  );

  function automatic bit out_win(logic [15:0] d, logic [15:0] lo, logic [15:0] hi);
    return (d <= lo) || (d > hi);
  endfunction

  function automatic int run_len(logic [1:0] p);
    return 1 << p;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // apply one cycle of stimulus, predict, then compare after the edge
  task automatic cycle(string tag, bit v, logic [1:0] ch, logic [15:0] d,
                       bit cd, bit clr);
    int  tgt, nxt;
    bit  trig;
    @(negedge clk);
    res_valid = v; res_chan = ch; res_data = d; conv_done = cd; stat_clr = clr;
    trig = 0;
    tgt  = run_len(persist_sel);
    if (chan_sel == 2'b00) m_cnt = 0;
    else if (v && ch == chan_sel) begin
      if (out_win(d, lo_thr, hi_thr)) begin
        nxt = (m_cnt + 1 > tgt) ? tgt : m_cnt + 1;
        m_cnt = nxt;
        trig = (nxt == tgt);
      end else m_cnt = 0;
    end
    if (trig) m_thr = 1; else if (clr) m_thr = 0;
    if (cd && done_irq_en) m_done = 1; else if (clr) m_done = 0;
    @(posedge clk); #1;
    check({tag, " thr_flag"}, thr_flag, m_thr);
    check({tag, " done_flag"}, done_flag, m_done);
    check({tag, " int_oe R10"}, int_oe, !sync_mode && (m_thr || m_done));
  endtask

  task automatic idle(string tag);
    cycle(tag, 0, 2'b00, 16'h0, 0, 0);
  endtask

  task automatic count_starts(string tag, int exp);
    int seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (sync_start) seen++;
    end
    n_chk++;
    if (seen != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d pulses expected %0d", tag, seen, exp);
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; res_valid = 0; res_chan = 0; res_data = 0; chan_sel = 0;
    persist_sel = 0; lo_thr = 16'h0000; hi_thr = 16'hFFFF; done_irq_en = 0;
    conv_done = 0; stat_clr = 0; sync_mode = 0; int_pin_in = 0;
    m_cnt = 0; m_thr = 0; m_done = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 thr_flag", thr_flag, 0);
    check("R1 done_flag", done_flag, 0);
    check("R1 int_oe", int_oe, 0);
    check("R1 sync_start", sync_start, 0);
    @(negedge clk); rst_n = 1;

    // R4 byte order, R3 edges: low 0x1234, high 0x8765, run length 1
    lo_thr = 16'h1234; hi_thr = 16'h8765; chan_sel = 2'b01; persist_sel = 2'b00;
    cycle("R4 just above low", 1, 2'b01, 16'h1235, 0, 0);
    cycle("R3 equal high in", 1, 2'b01, 16'h8765, 0, 0);
    cycle("R3 equal low out", 1, 2'b01, 16'h1234, 0, 0);
    cycle("R7 clear", 0, 2'b00, 16'h0, 0, 1);
    cycle("R3 above high out", 1, 2'b01, 16'h8766, 0, 0);
    cycle("R7 hold", 0, 2'b00, 16'h0, 0, 0);
    cycle("R7 clear2", 0, 2'b00, 16'h0, 0, 1);

    // R2 other colours and no-select
    cycle("R2 red ignored", 1, 2'b10, 16'h0000, 0, 0);
    chan_sel = 2'b00;
    cycle("R2 none", 1, 2'b00, 16'h0000, 0, 0);
    cycle("R2 none green", 1, 2'b01, 16'h0000, 0, 0);

    // R5 run length 4 with interleaved colours, R6 reset by in-window
    chan_sel = 2'b11; persist_sel = 2'b10;
    cycle("R5 miss1", 1, 2'b11, 16'h0010, 0, 0);
    cycle("R5 miss2", 1, 2'b11, 16'h0010, 0, 0);
    cycle("R6 in-window", 1, 2'b11, 16'h4000, 0, 0);
    cycle("R5 miss1b", 1, 2'b11, 16'h0010, 0, 0);
    cycle("R2 green no effect", 1, 2'b01, 16'h4000, 0, 0);
    cycle("R5 miss2b", 1, 2'b11, 16'hF000, 0, 0);
    cycle("R5 miss3b", 1, 2'b11, 16'hF000, 0, 0);
    cycle("R5 miss4b", 1, 2'b11, 16'hF000, 0, 0);
    // R8 retrigger at target wins over clear
    cycle("R8 clear vs trigger", 1, 2'b11, 16'hF000, 0, 1);
    cycle("R7 clear", 0, 2'b00, 16'h0, 0, 1);

    // R5 run length 8 and 2
    persist_sel = 2'b11;
    for (int i = 0; i < 8; i++) cycle("R5 run8", 1, 2'b11, 16'h0001, 0, 0);
    cycle("R7 clear", 0, 2'b00, 16'h0, 0, 1);
    persist_sel = 2'b01;
    cycle("R6 reset", 1, 2'b11, 16'h5000, 0, 0);
    cycle("R5 run2 a", 1, 2'b11, 16'h0001, 0, 0);
    cycle("R5 run2 b", 1, 2'b11, 16'h0001, 0, 0);
    cycle("R7 clear", 0, 2'b00, 16'h0, 0, 1);

    // R9 done source
    cycle("R9 disabled", 0, 2'b00, 16'h0, 1, 0);
    done_irq_en = 1;
    cycle("R9 set", 0, 2'b00, 16'h0, 1, 0);
    cycle("R9 hold", 0, 2'b00, 16'h0, 0, 0);
    cycle("R9 set beats clear", 0, 2'b00, 16'h0, 1, 1);
    cycle("R9 clear", 0, 2'b00, 16'h0, 0, 1);

    // R10 and R11 sync mode
    sync_mode = 1;
    cycle("R10 flags continue", 0, 2'b00, 16'h0, 1, 0);
    idle("R10 pad released");
    cycle("R9 clear", 0, 2'b00, 16'h0, 0, 1);
    @(negedge clk); int_pin_in = 1;
    count_starts("R11 one pulse", 1);
    @(negedge clk); int_pin_in = 0;
    count_starts("R11 falling no pulse", 0);
    @(negedge clk); sync_mode = 0;
    repeat (4) @(negedge clk);
    int_pin_in = 1;
    count_starts("R11 off no pulse", 0);
    @(negedge clk); int_pin_in = 0;
    repeat (4) @(negedge clk);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] d;
      if ($urandom_range(0, 40) == 0) begin
        chan_sel    = 2'($urandom);
        persist_sel = 2'($urandom);
        lo_thr      = 16'($urandom_range(0, 16'h7FFF));
        hi_thr      = lo_thr + 16'($urandom_range(0, 16'h3FFF));
        done_irq_en = 1'($urandom);
        sync_mode   = ($urandom_range(0, 3) == 0);
      end
      case ($urandom_range(0, 3))
        0: d = lo_thr;
        1: d = hi_thr + 16'($urandom_range(0, 1));
        default: d = 16'($urandom);
      endcase
      cycle("R5 random", $urandom_range(0, 2) != 0, 2'($urandom), d,
            $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule